// File: doc/BRIEF.md
# Glitchless Two-Input Clock Switch

This block picks one of two free-running input clocks and passes it to a single output clock. A select input chooses the source. When the select moves, the output never shows a shortened high or low phase. The old source is first gated off on one of its own falling edges. The output is then held low while the new source confirms the handover. After that, the new source is gated on at one of its own falling edges, so its first output pulse is a whole one.

The handover normally needs edges from both clocks. A slow reference clock therefore watches each input for activity. If the input that is being left behind has stopped, either high or low, a silence counter in the reference domain runs out. The old gate and its synchronizer are then cleared asynchronously, and the new clock takes over without waiting for edges that will never come. A status output names the input that drives the output. It changes only once the new input has really been gated through.

Top module: `clksw_top`

## Requirements
- R1: A low `selIn` selects `clkSrc0` and a high `selIn` selects `clkSrc1`. `activeSrc` reads 0 when `clkSrc0` drives the output and 1 when `clkSrc1` drives it, including the state after reset with `selIn` low.
- R2: During any switch, no high or low phase of `clkOut` is shorter than the shorter input half-period.
- R3: At most one input is gated to the output at any time. While the handover waits for the old input to release, `clkOut` is held low.
- R4: When both inputs run and the select changes, `clkOut` stays low for at least one full period of the newly selected input before it follows that input.
- R5: Once a handover is complete, `clkOut` equals the selected input.
- R6: If the selected input has stopped low and the select changes, `clkOut` follows the new input within 1 µs of the moment the old input stopped. This holds with the default timeout and a 50 MHz reference.
- R7: If the selected input has stopped high and the select changes, `clkOut` stays high until the silence timeout expires. It is then driven low and follows the new input within 1 µs of the stop.
- R8: Restarting an input that was stopped and is no longer selected has no effect on `clkOut`.
- R9: `activeSrc` keeps its old value right after the select changes. It changes only after the new input is gated to the output.
- R10: While `rstN` is low, `clkOut` is low and `activeSrc` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| refClk | input | 1 | Free-running reference clock, used only for the silence timeout and the status |
| rstN | input | 1 | Asynchronous active-low reset |
| clkSrc0 | input | 1 | Input clock chosen when `selIn` is low |
| clkSrc1 | input | 1 | Input clock chosen when `selIn` is high |
| selIn | input | 1 | Source select, asynchronous to every clock |
| clkOut | output | 1 | Switched output clock |
| activeSrc | output | 1 | Index of the input that currently drives `clkOut` |

## Verification
Switches between two running inputs of unrelated periods are made in both directions. They show whether the output gap covers a full new period and whether any phase is cut short. A stop of the selected input while it is low is separated from a stop while it is high: the first must leave the output low during the wait, and the second must leave it high until the timeout forces it low. Both must finish within the 1 µs bound. Restarting the abandoned input afterwards shows whether a released timeout can re-enable the wrong gate. On every reference cycle outside the handover windows, the output and the status are compared with a behavioural model of the select.

// File: rtl/clksw_pkg.sv
`timescale 1ns/100ps
package clksw_pkg;
  localparam int NUM_SRC = 2;

  // Strobes from the control block to the datapath
  typedef struct packed {
    logic [NUM_SRC-1:0] kill;   // asynchronous clear of one source's gate chain
  } clksw_strobe_t;
endpackage

// File: rtl/clksw_sync.sv
`timescale 1ns/100ps
module clksw_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic clrN,
  input  logic d,
  output logic q
);
  logic [STAGES-1:0] chain;

  always_ff @(posedge clk or negedge clrN) begin
    if (!clrN) chain <= '0;
    else       chain <= {chain[STAGES-2:0], d};
  end

  assign q = chain[STAGES-1];
endmodule

// File: rtl/clksw_datapath.sv
`timescale 1ns/100ps
module clksw_datapath
  import clksw_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic [NUM_SRC-1:0] clkIn,
  input  logic               rstN,
  input  logic               selIn,
  input  clksw_strobe_t      strobe,
  output logic               clkOut,
  output logic [NUM_SRC-1:0] gateOn,
  output logic [NUM_SRC-1:0] beat
);
  for (genvar i = 0; i < NUM_SRC; i++) begin : g_src
    localparam int   OTHER = NUM_SRC - 1 - i;
    localparam logic IDX   = 1'(i);

    logic want, req, reqSync, clrN, gateR, beatR;

    assign want = (selIn == IDX);
    // ask for the gate only while the other source is confirmed off
    assign req  = want & ~gateOn[OTHER];
    assign clrN = rstN & ~strobe.kill[i];

    clksw_sync #(.STAGES(SYNC_STAGES)) u_reqSync (
      .clk (clkIn[i]),
      .clrN(clrN),
      .d   (req),
      .q   (reqSync)
    );

    // gate changes only on the falling edge, so only while this input is low
    always_ff @(negedge clkIn[i] or negedge clrN) begin
      if (!clrN) gateR <= 1'b0;
      else       gateR <= reqSync;
    end

    // activity toggle, watched from the reference domain
    always_ff @(posedge clkIn[i] or negedge rstN) begin
      if (!rstN) beatR <= 1'b0;
      else       beatR <= ~beatR;
    end

    assign gateOn[i] = gateR;
    assign beat[i]   = beatR;

    p_gate_exclusive_r3: assert property (@(negedge clkIn[i]) disable iff (!rstN)
      gateR |-> !gateOn[OTHER]);
  end

  assign clkOut = |(clkIn & gateOn);
endmodule

// File: rtl/clksw_ctrl.sv
`timescale 1ns/100ps
module clksw_ctrl
  import clksw_pkg::*;
#(
  parameter int TIMEOUT_CYC = 32,
  parameter int SYNC_STAGES = 2
) (
  input  logic               refClk,
  input  logic               rstN,
  input  logic               selIn,
  input  logic [NUM_SRC-1:0] beat,
  input  logic [NUM_SRC-1:0] gateOn,
  output clksw_strobe_t      strobe,
  output logic               activeSrc
);
  localparam int              CW    = $clog2(TIMEOUT_CYC + 1);
  localparam logic [CW-1:0]   LIMIT = CW'(TIMEOUT_CYC);

  logic               selRef;
  logic [NUM_SRC-1:0] gateS;
  logic [NUM_SRC-1:0] killVec;

  clksw_sync #(.STAGES(SYNC_STAGES)) u_selSync (
    .clk(refClk), .clrN(rstN), .d(selIn), .q(selRef)
  );

  for (genvar i = 0; i < NUM_SRC; i++) begin : g_src
    localparam logic IDX = 1'(i);

    logic          beatS, beatPrev, edgeSeen, dead, killR, gateSl;
    logic [CW-1:0] silence;

    clksw_sync #(.STAGES(SYNC_STAGES)) u_beatSync (
      .clk(refClk), .clrN(rstN), .d(beat[i]), .q(beatS)
    );
    clksw_sync #(.STAGES(SYNC_STAGES)) u_gateSync (
      .clk(refClk), .clrN(rstN), .d(gateOn[i]), .q(gateSl)
    );

    assign edgeSeen = beatS ^ beatPrev;
    assign dead     = (silence == LIMIT);

    always_ff @(posedge refClk or negedge rstN) begin
      if (!rstN) begin
        beatPrev <= 1'b0;
        silence  <= '0;
        killR    <= 1'b0;
      end else begin
        beatPrev <= beatS;
        if (edgeSeen)   silence <= '0;
        else if (!dead) silence <= silence + 1'b1;
        // clear a silent source only once it is no longer wanted
        killR <= dead && (selRef != IDX);
      end
    end

    assign killVec[i] = killR;
    assign gateS[i]   = gateSl;

    p_kill_clears_gate_r6: assert property (@(posedge refClk) disable iff (!rstN)
      killR |-> !gateOn[i]);
    p_live_not_killed_r8: assert property (@(posedge refClk) disable iff (!rstN)
      edgeSeen |-> ##2 !killR);
  end

  always_comb strobe.kill = killVec;

  always_ff @(posedge refClk or negedge rstN) begin
    if (!rstN)                 activeSrc <= 1'b0;
    else if (gateS == 2'b10)   activeSrc <= 1'b1;
    else if (gateS == 2'b01)   activeSrc <= 1'b0;
  end

  p_status_after_handover_r9: assert property (@(posedge refClk) disable iff (!rstN)
    (activeSrc != $past(activeSrc)) |-> ($past(gateS) == (activeSrc ? 2'b10 : 2'b01)));
endmodule

// File: rtl/clksw_top.sv
`timescale 1ns/100ps
module clksw_top
  import clksw_pkg::*;
#(
  parameter int TIMEOUT_CYC = 32,
  parameter int SYNC_STAGES = 2
) (
  input  logic refClk,
  input  logic rstN,
  input  logic clkSrc0,
  input  logic clkSrc1,
  input  logic selIn,
  output logic clkOut,
  output logic activeSrc
);
  clksw_strobe_t      strobe;
  logic [NUM_SRC-1:0] gateOn;
  logic [NUM_SRC-1:0] beat;
  logic [NUM_SRC-1:0] clkVec;

  assign clkVec = {clkSrc1, clkSrc0};

  clksw_ctrl #(.TIMEOUT_CYC(TIMEOUT_CYC), .SYNC_STAGES(SYNC_STAGES)) u_ctrl (
    .refClk   (refClk),
    .rstN     (rstN),
    .selIn    (selIn),
    .beat     (beat),
    .gateOn   (gateOn),
    .strobe   (strobe),
    .activeSrc(activeSrc)
  );

  clksw_datapath #(.SYNC_STAGES(SYNC_STAGES)) u_dp (
    .clkIn (clkVec),
    .rstN  (rstN),
    .selIn (selIn),
    .strobe(strobe),
    .clkOut(clkOut),
    .gateOn(gateOn),
    .beat  (beat)
  );
endmodule

// File: tb/clksw_top_tb.sv
`timescale 1ns/100ps
module clksw_top_tb;
  logic refClk = 1'b0;
  logic rstN = 1'b0;
  logic clkSrc0 = 1'b0;
  logic clkSrc1 = 1'b0;
  logic selIn = 1'b0;
  logic clkOut, activeSrc;
  bit   run0 = 1'b1, run1 = 1'b1;
  bit   monOn = 1'b0, done = 1'b0;
  int   nChecks = 0, nFails = 0;
  realtime lastEdgeT = 0, maxLow = 0, tStop = 0;

  clksw_top u_dut (
    .refClk(refClk), .rstN(rstN), .clkSrc0(clkSrc0), .clkSrc1(clkSrc1),
    .selIn(selIn), .clkOut(clkOut), .activeSrc(activeSrc)
  );

  always #10 refClk = ~refClk;                       // 50 MHz reference
  initial forever begin #4; if (run0) clkSrc0 = ~clkSrc0; end        // 8 ns
  initial begin #0.5; forever begin #7; if (run1) clkSrc1 = ~clkSrc1; end end  // 14 ns

  task automatic check(input bit ok, input string req, input int act, input int exp);
    nChecks++;
    if (!ok) begin
      nFails++;
      $display("FAIL %s act=%0d exp=%0d at %0t", req, act, exp, $realtime);
    end
  endtask

  // phase-width monitor: R2 runt detection and R4 low-gap measurement
  always @(clkOut) begin
    realtime w;
    w = $realtime - lastEdgeT;
    if (monOn) begin
      check(w >= 3.9, "R2 phase shorter than input half-period", int'(w), 4);
      if (clkOut && w > maxLow) maxLow = w;
    end
    lastEdgeT = $realtime;
  end

  // reference model: output equals the selected input, status names it
  task automatic compare(input int n, input bit expS, input string req);
    for (int k = 0; k < n; k++) begin
      @(negedge refClk); #1;
      check(clkOut === (expS ? clkSrc1 : clkSrc0), req, clkOut, expS ? clkSrc1 : clkSrc0);
      check(activeSrc === expS, {req, " R1 status"}, activeSrc, expS);
    end
  endtask

  task automatic doSwitch(input bit v, input int newPeriod, input string req);
    @(negedge refClk); #3;
    selIn = v;
    maxLow = 0;
    #5;
    check(activeSrc === !v, "R9 status holds old source", activeSrc, !v);
    repeat (15) @(negedge refClk);
    check(maxLow >= newPeriod, "R4 handover low gap", int'(maxLow), newPeriod);
    compare(20, v, req);
  endtask

  task automatic finishRun();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
    $finish;
  endtask

  initial begin
    #200000;
    if (!done) begin
      nChecks++; nFails++;
      $display("FAIL R5 watchdog expired act=0 exp=1");
      finishRun();
    end
  end

  initial begin
    for (int k = 0; k < 3; k++) begin
      @(negedge refClk); #1;
      check(clkOut === 1'b0, "R10 reset output", clkOut, 0);
      check(activeSrc === 1'b0, "R10 reset status", activeSrc, 0);
    end
    @(negedge refClk); rstN = 1'b1;
    repeat (10) @(negedge refClk);
    monOn = 1'b1;
    compare(20, 1'b0, "R1 after reset");

    doSwitch(1'b1, 14, "R5 running 0->1");
    doSwitch(1'b0, 8,  "R5 running 1->0");

    // selected input stops low
    @(negedge clkSrc0); tStop = $realtime; #1 run0 = 1'b0;
    #10 selIn = 1'b1;
    #389;
    check(clkOut === 1'b0, "R3 output low while handover waits", clkOut, 0);
    #600;
    compare(10, 1'b1, "R6 stopped-low timeout");

    // abandoned input restarts
    run0 = 1'b1;
    repeat (30) @(negedge refClk);
    compare(10, 1'b1, "R8 restart of unselected input");

    // selected input stops high
    @(posedge clkSrc1); tStop = $realtime; #1 run1 = 1'b0;
    #10 selIn = 1'b0;
    #389;
    check(clkOut === 1'b1, "R7 output held high before timeout", clkOut, 1);
    #600;
    compare(10, 1'b0, "R7 stopped-high timeout");

    run1 = 1'b1;
    repeat (30) @(negedge refClk);
    doSwitch(1'b1, 14, "R1 recovery switch");

    done = 1'b1;
    finishRun();
  end
endmodule